// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block sits beside an asynchronous SRAM-style access port and watches each access as it goes by. A hidden command is requested by reading six fixed addresses back to back. Five fixed addresses open the run, and the sixth address chooses one of four commands: commit the array to nonvolatile storage, reload the array from nonvolatile storage, turn automatic power-down saving off, or turn it back on. When a run completes, the block raises a single-clock command pulse carrying a 2-bit code. Any other access that breaks into the run cancels it quietly.

The interface logic upstream turns each access into one strobe cycle. An access may be marked by a falling chip-enable or by a falling output-enable, and output-enable need not be low for a read to count. All reads in the run still return array data as usual; this block only observes them. While the command is executing, a busy input freezes the matcher.

Top module: `cmd_seq_detector`

## Requirements
- R1: A command can only follow five reads whose low 14 address bits are 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in exactly that order.
- R2: When the access after those five is a read, its low 14 bits select the code: 0x0FC0 gives 2'b00 (store), 0x0C63 gives 2'b01 (recall), 0x03F8 gives 2'b10 (auto-save off) and 0x07F0 gives 2'b11 (auto-save on). cmd_valid is high, with that code, during the clock cycle that follows the edge at which the sixth access is sampled.
- R3: Address bit 14 plays no part in matching. A run made with that bit set behaves exactly like one made with it clear.
- R4: A write accepted at any point of a run aborts it, and no command is issued for that run.
- R5: A read to any address other than the next expected one aborts the run, and no command is issued. This includes a sixth address that is not one of the four command addresses.
- R6: The access that aborts a run is itself checked against the first address, so a new run may start on that same access.
- R7: cmd_valid stays high for one clock only. Afterwards the matcher is idle, and a new command needs all six reads again.
- R8: While busy is high, accesses are ignored and the progress of a run is kept.
- R9: A synchronous active-high reset returns the matcher to idle and holds cmd_valid low.
- R10: Clock cycles without an access strobe do not change the progress of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle strobe per access |
| acc_write | input | 1 | High when the access is a write |
| acc_addr | input | ADDR_W (15) | Access address |
| busy | input | 1 | Command executing; accesses are ignored |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | Command code, valid with cmd_valid |

## Verification
The bench targets runs that are almost right: a write placed on a prefix address, a prefix read out of order, and a wrong sixth address. A design that does not abort on these would issue a command it should not. An abort that lands on 0x0E38 has to restart the run right away, so a design that always falls back to idle would miss the recall that follows. The bench also sets bit 14 on every address, inserts gaps between strobes, applies busy in the middle of a run, and applies reset in the middle of a run. A design that matched all 15 bits, dropped progress on gaps or busy, or kept progress through reset would give the wrong pulse or no pulse. Finally, the bench repeats only the sixth read straight after a command, to catch a matcher that does not return to idle.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int MATCH_W    = 14;
    localparam int PREFIX_LEN = 5;
    localparam int NUM_CMDS   = 4;
    localparam int STATE_W    = $clog2(PREFIX_LEN + 1);
    localparam int CODE_W     = $clog2(NUM_CMDS);

    typedef logic [MATCH_W-1:0] key_t;

    typedef enum logic [CODE_W-1:0] {
        CMD_STORE  = 2'd0,
        CMD_RECALL = 2'd1,
        CMD_AS_OFF = 2'd2,
        CMD_AS_ON  = 2'd3
    } cmd_code_e;

    // State value n means n prefix reads matched so far.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_K4   = 3'd4,
        ST_K5   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic write;
        key_t key;
    } access_t;

    typedef struct packed {
        logic      valid;
        cmd_code_e code;
    } cmd_t;

    function automatic key_t prefix_key(input int idx);
        case (idx)
            0:       return 14'h0E38;
            1:       return 14'h31C7;
            2:       return 14'h03E0;
            3:       return 14'h3C1F;
            default: return 14'h303F;
        endcase
    endfunction

    function automatic key_t cmd_key(input int idx);
        case (idx)
            0:       return 14'h0FC0;
            1:       return 14'h0C63;
            2:       return 14'h03F8;
            default: return 14'h07F0;
        endcase
    endfunction

    function automatic seq_state_e advance(input seq_state_e s);
        return seq_state_e'(STATE_W'(s) + STATE_W'(1));
    endfunction

endpackage

// File: rtl/cmdseq_key_match.sv
module cmdseq_key_match
    import cmdseq_pkg::*;
(
    input  key_t                  key,
    output logic [PREFIX_LEN-1:0] prefix_hit,
    output logic                  cmd_hit,
    output cmd_code_e             cmd_code
);

    logic [NUM_CMDS-1:0] cmd_hit_vec;

    for (genvar p = 0; p < PREFIX_LEN; p++) begin : g_prefix
        assign prefix_hit[p] = (key == prefix_key(p));
    end

    for (genvar c = 0; c < NUM_CMDS; c++) begin : g_cmd
        assign cmd_hit_vec[c] = (key == cmd_key(c));
    end

    assign cmd_hit = |cmd_hit_vec;

    always_comb begin
        cmd_code = CMD_STORE;
        for (int c = 0; c < NUM_CMDS; c++) begin
            if (cmd_hit_vec[c]) cmd_code = cmd_code_e'(c[CODE_W-1:0]);
        end
    end

    // The four command keys are distinct, so no address hits two of them (R2).
    always_comb begin
        assert_cmd_keys_distinct_R2: assert ($onehot0(cmd_hit_vec));
    end

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
    import cmdseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  access_t               acc,
    input  logic                  busy,
    input  logic [PREFIX_LEN-1:0] prefix_hit,
    input  logic                  cmd_hit,
    input  cmd_code_e             cmd_code,
    output cmd_t                  issue
);

    seq_state_e state, state_nxt;
    logic       take;

    assign take = acc.valid && !busy;

    always_comb begin
        state_nxt   = state;
        issue.valid = 1'b0;
        issue.code  = cmd_code;
        if (take) begin
            if (acc.write) begin
                state_nxt = ST_IDLE;
            end else if (state == ST_K5 && cmd_hit) begin
                state_nxt   = ST_IDLE;
                issue.valid = 1'b1;
            end else if (state != ST_K5 && prefix_hit[state]) begin
                state_nxt = advance(state);
            end else if (prefix_hit[0]) begin
                state_nxt = ST_K1;
            end else begin
                state_nxt = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    assert_write_aborts_R4: assert property (@(posedge clk) disable iff (rst)
        (acc.valid && acc.write && !busy) |=> (state == ST_IDLE));

    assert_busy_freezes_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (state == $past(state)));

    assert_gap_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !acc.valid |=> (state == $past(state)));

    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));

endmodule

// File: rtl/cmdseq_pulse.sv
module cmdseq_pulse
    import cmdseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmd_t      issue,
    output logic      cmd_valid,
    output cmd_code_e cmd_code
);

    cmd_t out_q;

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= issue;
    end

    assign cmd_valid = out_q.valid;
    assign cmd_code  = out_q.code;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/cmd_seq_detector.sv
module cmd_seq_detector
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              busy,
    output logic              cmd_valid,
    output logic [1:0]        cmd_code
);

    access_t                acc;
    logic [PREFIX_LEN-1:0]  prefix_hit;
    logic                   cmd_hit;
    cmd_code_e              match_code;
    cmd_t                   issue;
    cmd_code_e              code_q;

    assign acc.valid = acc_valid;
    assign acc.write = acc_write;
    assign acc.key   = acc_addr[MATCH_W-1:0];

    // Bits above the match width take no part in matching (R3).
    if (ADDR_W > MATCH_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^acc_addr[ADDR_W-1:MATCH_W];
    end

    cmdseq_key_match u_match (
        .key        (acc.key),
        .prefix_hit (prefix_hit),
        .cmd_hit    (cmd_hit),
        .cmd_code   (match_code)
    );

    cmdseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .busy       (busy),
        .prefix_hit (prefix_hit),
        .cmd_hit    (cmd_hit),
        .cmd_code   (match_code),
        .issue      (issue)
    );

    cmdseq_pulse u_pulse (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .cmd_valid (cmd_valid),
        .cmd_code  (code_q)
    );

    assign cmd_code = code_q;

    assert_cmd_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(acc_valid && !acc_write && !busy));

endmodule

// File: tb/cmd_seq_detector_bench.sv
module cmd_seq_detector_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       v;
        logic [1:0] code;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [14:0] acc_addr = '0;
    logic        busy = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_code;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_seq_detector u_cmd_seq_detector (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .busy(busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    function automatic logic [14:0] pfx(input int i);
        case (i)
            0: return 15'h0E38;
            1: return 15'h31C7;
            2: return 15'h03E0;
            3: return 15'h3C1F;
            default: return 15'h303F;
        endcase
    endfunction

    // Driver: one call per clock cycle, pushes the expected output for that cycle.
    task automatic step(input logic r, input logic v, input logic wr, input logic bz,
                        input logic [14:0] a, input logic ev, input logic [1:0] ec,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; acc_valid = v; acc_write = wr; busy = bz; acc_addr = a;
        e.v = ev; e.code = ec; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic rd(input logic [14:0] a, input logic ev, input logic [1:0] ec, input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b0, a, ev, ec, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 15'h0, 1'b0, 2'b00, tag);
    endtask

    task automatic prefix(input int n, input logic hi, input string tag);
        for (int i = 0; i < n; i++) rd(pfx(i) | {hi, 14'h0}, 1'b0, 2'b00, tag);
    endtask

    // Monitor: compares a quarter period after each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_vec++;
                if (cmd_valid !== e.v || (e.v && cmd_code !== e.code)) begin
                    n_bad++;
                    $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
                             e.tag, cmd_valid, cmd_code, e.v, e.code);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 15'h0, 1'b0, 2'b00, "R9 reset");
        idle(1, "R9 idle after reset");

        // R1 R2: store
        prefix(5, 1'b0, "R1 prefix");
        rd(15'h0FC0, 1'b1, 2'b00, "R2 store");
        idle(1, "R7 pulse ends");

        // R2 R10: recall with gaps between strobes
        for (int i = 0; i < 5; i++) begin
            rd(pfx(i), 1'b0, 2'b00, "R10 prefix gap");
            idle(2, "R10 gap");
        end
        rd(15'h0C63, 1'b1, 2'b01, "R10 recall after gaps");
        idle(1, "R7 pulse ends");

        // R3: top bit set everywhere, auto-save off
        prefix(5, 1'b1, "R3 prefix hi");
        rd(15'h43F8, 1'b1, 2'b10, "R3 auto-save off");
        idle(1, "R7");

        // R2: auto-save on
        prefix(5, 1'b0, "R2 prefix");
        rd(15'h07F0, 1'b1, 2'b11, "R2 auto-save on");

        // R7: sixth read alone right after a command
        rd(15'h0FC0, 1'b0, 2'b00, "R7 sixth alone");
        idle(1, "R7");

        // R4: write inside run
        prefix(3, 1'b0, "R4 prefix");
        step(1'b0, 1'b1, 1'b1, 1'b0, 15'h3C1F, 1'b0, 2'b00, "R4 write");
        rd(15'h303F, 1'b0, 2'b00, "R4 continue");
        rd(15'h0FC0, 1'b0, 2'b00, "R4 no command");
        idle(1, "R4");

        // R4: write to the sixth address
        prefix(5, 1'b0, "R4 prefix");
        step(1'b0, 1'b1, 1'b1, 1'b0, 15'h0FC0, 1'b0, 2'b00, "R4 write sixth");
        idle(1, "R4");

        // R5: out of order
        rd(15'h0E38, 1'b0, 2'b00, "R5 a");
        rd(15'h03E0, 1'b0, 2'b00, "R5 skip");
        rd(15'h3C1F, 1'b0, 2'b00, "R5 b");
        rd(15'h303F, 1'b0, 2'b00, "R5 c");
        rd(15'h0C63, 1'b0, 2'b00, "R5 no command");

        // R5: stray read before sixth, and a non-command sixth
        prefix(5, 1'b0, "R5 prefix");
        rd(15'h1234, 1'b0, 2'b00, "R5 stray");
        rd(15'h0FC0, 1'b0, 2'b00, "R5 no command after stray");
        prefix(5, 1'b0, "R5 prefix");
        rd(15'h0FC1, 1'b0, 2'b00, "R5 bad sixth");
        idle(1, "R5");

        // R6: abort on first address restarts the run
        rd(15'h0E38, 1'b0, 2'b00, "R6 a");
        rd(15'h31C7, 1'b0, 2'b00, "R6 b");
        rd(15'h0E38, 1'b0, 2'b00, "R6 restart");
        for (int i = 1; i < 5; i++) rd(pfx(i), 1'b0, 2'b00, "R6 rest");
        rd(15'h0C63, 1'b1, 2'b01, "R6 recall");
        // R6: abort at the sixth slot by first address
        prefix(5, 1'b0, "R6 prefix");
        rd(15'h0E38, 1'b0, 2'b00, "R6 restart at sixth");
        for (int i = 1; i < 5; i++) rd(pfx(i), 1'b0, 2'b00, "R6 rest");
        rd(15'h03F8, 1'b1, 2'b10, "R6 auto-save off");
        idle(1, "R6");

        // R8: busy access mid-run is ignored
        prefix(3, 1'b0, "R8 prefix");
        step(1'b0, 1'b1, 1'b0, 1'b1, 15'h1111, 1'b0, 2'b00, "R8 busy read");
        step(1'b0, 1'b1, 1'b1, 1'b1, 15'h2222, 1'b0, 2'b00, "R8 busy write");
        rd(15'h3C1F, 1'b0, 2'b00, "R8 d");
        rd(15'h303F, 1'b0, 2'b00, "R8 e");
        rd(15'h07F0, 1'b1, 2'b11, "R8 command kept");
        // R8: full run while busy gives nothing
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b1, pfx(i), 1'b0, 2'b00, "R8 busy run");
        step(1'b0, 1'b1, 1'b0, 1'b1, 15'h0FC0, 1'b0, 2'b00, "R8 busy sixth");
        idle(1, "R8");

        // R9: reset mid-run
        prefix(4, 1'b0, "R9 prefix");
        step(1'b1, 1'b0, 1'b0, 1'b0, 15'h0, 1'b0, 2'b00, "R9 reset mid");
        rd(15'h303F, 1'b0, 2'b00, "R9 e");
        rd(15'h0FC0, 1'b0, 2'b00, "R9 no command");
        idle(3, "R9 tail");

        wait (exp_q.size() == 0);
        @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule